// File: doc/BRIEF.md
# Message-Object Transfer Command Engine

This block moves field groups between a CPU-facing interface register set and one message object held in an on-block message RAM. Software first loads the interface registers (mask, arbitration, control, data bytes 0–3), then writes a 32-bit command word. The word gives the transfer direction, one enable flag for each field group, two status-control flags and an 8-bit object number. The engine runs a fixed four-cycle read-modify-write. It reads the addressed object, merges the selected groups, writes the object back and then updates the interface registers. A busy output is high for the whole sequence.

Status bits inside the object's control word change as a side effect of the transfer. A read can clear the interrupt-pending bit and the new-data bit. The copy placed in the interface control register still shows their values from before the clear. A write can force the transmit-request and new-data bits high, whatever the interface control register holds. The RAM model is a flat register file of `NUM_OBJ` objects, numbered from 1.

Top module: `msgx_engine`

## Requirements
- R1: Command bit 23 selects the direction. With 1 (write), the selected groups go from the interface registers into the addressed object and the interface registers are left unchanged. With 0 (read), the selected groups go from the object into the interface registers. Bits 31:24 are don't-care and bits 7:0 give the object number.
- R2: Bits 22, 21, 20 and 17 enable the mask group (31 bits), the arbitration group (32 bits), the control group (16 bits) and the data group (32 bits). A group whose flag is 0 keeps its old value in the destination.
- R3: On a read, bit 19 clears the object's interrupt-pending bit (control bit 14). On a write, bit 19 has no effect, and control bit 14 reaches the object only through the control group.
- R4: On a read, bit 18 clears the object's new-data bit (control bit 15).
- R5: On a read that also clears status bits, the interface control register receives the object's control word as it was before the clear.
- R6: On a write with bit 18 set, the object's control bits 15 (new data) and 13 (transmit request) become 1. This holds whether or not the control group is written and whatever the interface control value is. With bit 18 clear, those bits follow the control group alone.
- R7: An accepted command raises busy on the next cycle. Busy stays high for exactly 4 cycles whatever groups are selected. The interface registers show the result when busy falls.
- R8: A command word written while busy is ignored and alters no object.
- R9: An object number of 0 or above `NUM_OBJ` (32) starts no transfer. Busy stays low and the RAM and interface registers are unchanged.
- R10: After reset, busy is 0 and every interface register and every RAM object is zero.
- R11: A pulse on `ifr_load` while idle loads all four interface registers on the next edge. While busy, the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| ifr_load | input | 1 | Load strobe for the interface registers |
| ifr_mask_d | input | 31 | Mask group value to load |
| ifr_arb_d | input | 32 | Arbitration group value to load |
| ifr_ctrl_d | input | 16 | Control group value to load |
| ifr_data_d | input | 32 | Data bytes 0–3 to load |
| busy | output | 1 | Transfer in progress |
| ifr_mask_q | output | 31 | Interface mask register |
| ifr_arb_q | output | 32 | Interface arbitration register |
| ifr_ctrl_q | output | 16 | Interface control register |
| ifr_data_q | output | 32 | Interface data register |

## Verification
The assertions assume that `cmd_wr` and `ifr_load` are never raised in the same cycle. They also assume that software does not rely on a load landing in the cycle the engine updates the interface registers. The stimulus drives every strobe at the falling edge for exactly one cycle, and it raises both strobes together only inside the busy window, where the ignore rules apply. Object numbers outside 1..32 appear only in the out-of-range tests.

// File: rtl/msgx_pkg.sv
package msgx_pkg;
  localparam int ID_W    = 29;
  localparam int MASK_W  = ID_W + 2;
  localparam int ARB_W   = ID_W + 3;
  localparam int CTRL_W  = 16;
  localparam int DATA_W  = 32;
  localparam int NUM_W   = 8;

  localparam int CB_NEWDAT = 15;
  localparam int CB_INTPND = 14;
  localparam int CB_TXRQST = 13;

  localparam int KB_DIR   = 23;
  localparam int KB_MASK  = 22;
  localparam int KB_ARB   = 21;
  localparam int KB_CTRL  = 20;
  localparam int KB_CLRIP = 19;
  localparam int KB_TXND  = 18;
  localparam int KB_DATA  = 17;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [ARB_W-1:0]  arb;
    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0] data;
  } obj_t;

  typedef struct packed {
    logic             wr;
    logic             g_mask;
    logic             g_arb;
    logic             g_ctrl;
    logic             g_data;
    logic             clr_ip;
    logic             txnd;
    logic [NUM_W-1:0] num;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.wr     = w[KB_DIR];
    c.g_mask = w[KB_MASK];
    c.g_arb  = w[KB_ARB];
    c.g_ctrl = w[KB_CTRL];
    c.clr_ip = w[KB_CLRIP];
    c.txnd   = w[KB_TXND];
    c.g_data = w[KB_DATA];
    c.num    = w[NUM_W-1:0];
    return c;
  endfunction

  function automatic logic num_in_range(input logic [NUM_W-1:0] n, input int unsigned nobj);
    return (n != '0) && (32'(n) <= nobj);
  endfunction

  // New object contents after the transfer.
  function automatic obj_t merge_obj(input cmd_t c, input obj_t o, input obj_t f);
    obj_t r;
    r = o;
    if (c.wr) begin
      if (c.g_mask) r.mask = f.mask;
      if (c.g_arb)  r.arb  = f.arb;
      if (c.g_ctrl) r.ctrl = f.ctrl;
      if (c.g_data) r.data = f.data;
      if (c.txnd) begin
        r.ctrl[CB_NEWDAT] = 1'b1;
        r.ctrl[CB_TXRQST] = 1'b1;
      end
    end else begin
      if (c.clr_ip) r.ctrl[CB_INTPND] = 1'b0;
      if (c.txnd)   r.ctrl[CB_NEWDAT] = 1'b0;
    end
    return r;
  endfunction

  // New interface register contents; reads use the pre-clear object.
  function automatic obj_t merge_ifr(input cmd_t c, input obj_t o, input obj_t f);
    obj_t r;
    r = f;
    if (!c.wr) begin
      if (c.g_mask) r.mask = o.mask;
      if (c.g_arb)  r.arb  = o.arb;
      if (c.g_ctrl) r.ctrl = o.ctrl;
      if (c.g_data) r.data = o.data;
    end
    return r;
  endfunction
endpackage

// File: rtl/msgx_objram.sv
module msgx_objram
  import msgx_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output obj_t             rd_obj,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  obj_t             wr_obj
);
  obj_t mem [NUM_OBJ];

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic hit;
    assign hit = we && (32'(wr_idx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= wr_obj;
    end
  end

  always_comb begin
    rd_obj = '0;
    if (32'(rd_idx) < NUM_OBJ) rd_obj = mem[rd_idx];
  end
endmodule

// File: rtl/msgx_seq.sv
module msgx_seq
  import msgx_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  output logic        busy,
  output logic        accept,
  output logic        cap_en,
  output logic        mrg_en,
  output logic        wb_en,
  output logic        upd_en,
  output cmd_t        cmd_q
);
  typedef enum logic [2:0] {S_IDLE, S_CAP, S_MRG, S_WB, S_UPD} st_e;
  st_e  state;
  cmd_t dec;
  logic num_ok;

  assign dec    = decode_cmd(cmd_word);
  assign num_ok = num_in_range(dec.num, NUM_OBJ);
  assign busy   = (state != S_IDLE);
  assign accept = cmd_wr && !busy && num_ok;
  assign cap_en = (state == S_CAP);
  assign mrg_en = (state == S_MRG);
  assign wb_en  = (state == S_WB);
  assign upd_en = (state == S_UPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cmd_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state <= S_CAP;
          cmd_q <= dec;
        end
        S_CAP:   state <= S_MRG;
        S_MRG:   state <= S_WB;
        S_WB:    state <= S_UPD;
        S_UPD:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r7_busy_ends_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> !busy);
  a_r8_cmd_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  a_r9_bad_number_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !num_ok) |=> !busy);
endmodule

// File: rtl/msgx_merge.sv
module msgx_merge
  import msgx_pkg::*;
(
  input  cmd_t cmd,
  input  obj_t obj_in,
  input  obj_t ifr_in,
  output obj_t obj_out,
  output obj_t ifr_out
);
  assign obj_out = merge_obj(cmd, obj_in, ifr_in);
  assign ifr_out = merge_ifr(cmd, obj_in, ifr_in);
endmodule

// File: rtl/msgx_engine.sv
module msgx_engine
  import msgx_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic              ifr_load,
  input  logic [MASK_W-1:0] ifr_mask_d,
  input  logic [ARB_W-1:0]  ifr_arb_d,
  input  logic [CTRL_W-1:0] ifr_ctrl_d,
  input  logic [DATA_W-1:0] ifr_data_d,
  output logic              busy,
  output logic [MASK_W-1:0] ifr_mask_q,
  output logic [ARB_W-1:0]  ifr_arb_q,
  output logic [CTRL_W-1:0] ifr_ctrl_q,
  output logic [DATA_W-1:0] ifr_data_q
);
  logic accept, cap_en, mrg_en, wb_en, upd_en;
  cmd_t cmd_q;
  obj_t ram_rd, obj_q, nobj_q, nifr_q, ifr_q, mobj, mifr;
  logic [IDX_W-1:0] idx;
  logic load_ok;

  msgx_seq #(.NUM_OBJ(NUM_OBJ)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .busy(busy), .accept(accept), .cap_en(cap_en), .mrg_en(mrg_en),
    .wb_en(wb_en), .upd_en(upd_en), .cmd_q(cmd_q)
  );

  assign idx = IDX_W'(cmd_q.num - 1'b1);

  msgx_objram #(.NUM_OBJ(NUM_OBJ)) u_ram (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_obj(ram_rd),
    .we(wb_en), .wr_idx(idx), .wr_obj(nobj_q)
  );

  msgx_merge u_merge (
    .cmd(cmd_q), .obj_in(obj_q), .ifr_in(ifr_q),
    .obj_out(mobj), .ifr_out(mifr)
  );

  assign load_ok = ifr_load && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obj_q  <= '0;
      nobj_q <= '0;
      nifr_q <= '0;
      ifr_q  <= '0;
    end else begin
      if (cap_en) obj_q <= ram_rd;
      if (mrg_en) begin
        nobj_q <= mobj;
        nifr_q <= mifr;
      end
      if (upd_en) ifr_q <= nifr_q;
      else if (load_ok) begin
        ifr_q.mask <= ifr_mask_d;
        ifr_q.arb  <= ifr_arb_d;
        ifr_q.ctrl <= ifr_ctrl_d;
        ifr_q.data <= ifr_data_d;
      end
    end
  end

  assign ifr_mask_q = ifr_q.mask;
  assign ifr_arb_q  = ifr_q.arb;
  assign ifr_ctrl_q = ifr_q.ctrl;
  assign ifr_data_q = ifr_q.data;

  a_r6_tx_forces_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && cmd_q.wr && cmd_q.txnd) |-> (nobj_q.ctrl[CB_NEWDAT] && nobj_q.ctrl[CB_TXRQST]));
  a_r1_read_keeps_object_groups: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !cmd_q.wr) |-> (nobj_q.mask == obj_q.mask && nobj_q.arb == obj_q.arb
                              && nobj_q.data == obj_q.data));
  a_r1_write_keeps_interface: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && cmd_q.wr) |=> $stable(ifr_q));
  a_r5_read_shows_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !cmd_q.wr && cmd_q.g_ctrl) |=> (ifr_ctrl_q == obj_q.ctrl));
  a_r11_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !upd_en) |=> $stable(ifr_q));
endmodule

// File: tb/msgx_engine_test.sv
`timescale 1ns/1ps
module msgx_engine_test;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic ifr_load = 1'b0;
  logic [30:0] ifr_mask_d = '0;
  logic [31:0] ifr_arb_d = '0;
  logic [15:0] ifr_ctrl_d = '0;
  logic [31:0] ifr_data_d = '0;
  logic busy;
  logic [30:0] ifr_mask_q;
  logic [31:0] ifr_arb_q;
  logic [15:0] ifr_ctrl_q;
  logic [31:0] ifr_data_q;

  int n_run = 0;
  int n_fail = 0;

  logic [30:0] m_mask [1:N];
  logic [31:0] m_arb  [1:N];
  logic [15:0] m_ctrl [1:N];
  logic [31:0] m_data [1:N];
  logic [30:0] e_mask;
  logic [31:0] e_arb;
  logic [15:0] e_ctrl;
  logic [31:0] e_data;

  localparam logic [31:0] WR = 32'h0080_0000;
  localparam logic [31:0] GM = 32'h0040_0000;
  localparam logic [31:0] GA = 32'h0020_0000;
  localparam logic [31:0] GC = 32'h0010_0000;
  localparam logic [31:0] CI = 32'h0008_0000;
  localparam logic [31:0] TX = 32'h0004_0000;
  localparam logic [31:0] GD = 32'h0002_0000;
  localparam logic [31:0] ALL = GM | GA | GC | GD;

  msgx_engine #(.NUM_OBJ(N)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .ifr_load(ifr_load), .ifr_mask_d(ifr_mask_d), .ifr_arb_d(ifr_arb_d),
    .ifr_ctrl_d(ifr_ctrl_d), .ifr_data_d(ifr_data_d), .busy(busy),
    .ifr_mask_q(ifr_mask_q), .ifr_arb_q(ifr_arb_q), .ifr_ctrl_q(ifr_ctrl_q),
    .ifr_data_q(ifr_data_q)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_ifr(input string req);
    chk(ifr_mask_q == e_mask, req, 64'(ifr_mask_q), 64'(e_mask));
    chk(ifr_arb_q  == e_arb,  req, 64'(ifr_arb_q),  64'(e_arb));
    chk(ifr_ctrl_q == e_ctrl, req, 64'(ifr_ctrl_q), 64'(e_ctrl));
    chk(ifr_data_q == e_data, req, 64'(ifr_data_q), 64'(e_data));
  endtask

  function automatic logic [31:0] pat(input int s, input int k);
    return (32'(s) * 32'h9E37_79B1) ^ (32'(k) * 32'h85EB_CA6B) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic load(input logic [30:0] m, input logic [31:0] a, input logic [15:0] c, input logic [31:0] d);
    @(negedge clk);
    ifr_load = 1'b1; ifr_mask_d = m; ifr_arb_d = a; ifr_ctrl_d = c; ifr_data_d = d;
    @(negedge clk);
    ifr_load = 1'b0;
    e_mask = m; e_arb = a; e_ctrl = c; e_data = d;
    chk_ifr("R11 load");
  endtask

  task automatic model(input logic [31:0] w);
    int n;
    n = int'(w[7:0]);
    if (w[23]) begin
      if (w[22]) m_mask[n] = e_mask;
      if (w[21]) m_arb[n]  = e_arb;
      if (w[20]) m_ctrl[n] = e_ctrl;
      if (w[17]) m_data[n] = e_data;
      if (w[18]) m_ctrl[n] = m_ctrl[n] | 16'hA000;
    end else begin
      if (w[22]) e_mask = m_mask[n];
      if (w[21]) e_arb  = m_arb[n];
      if (w[20]) e_ctrl = m_ctrl[n];
      if (w[17]) e_data = m_data[n];
      if (w[19]) m_ctrl[n][14] = 1'b0;
      if (w[18]) m_ctrl[n][15] = 1'b0;
    end
  endtask

  // Runs a command; optional second strobe pair during busy (R8/R11).
  task automatic run(input logic [31:0] w, input string req, input logic poke, input logic [31:0] w2);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy == 1'b1, "R7 busy cycle 1", 64'(busy), 64'd1);
    if (poke) begin
      cmd_wr = 1'b1; cmd_word = w2; ifr_load = 1'b1;
      ifr_mask_d = 31'h1234_5678; ifr_arb_d = 32'hDEAD_BEEF;
      ifr_ctrl_d = 16'hFFFF; ifr_data_d = 32'hCAFE_F00D;
    end
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      cmd_wr = 1'b0; ifr_load = 1'b0;
      chk(busy == 1'b1, "R7 busy held", 64'(busy), 64'd1);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy falls after 4", 64'(busy), 64'd0);
    model(w);
    chk_ifr(req);
  endtask

  task automatic bad(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy == 1'b0, "R9 no start", 64'(busy), 64'd0);
    @(negedge clk);
    chk_ifr("R9 interface unchanged");
  endtask

  task automatic readback_all(input string req);
    for (int n = 1; n <= N; n++) run(ALL | 32'(n), req, 1'b0, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int n = 1; n <= N; n++) begin
      m_mask[n] = '0; m_arb[n] = '0; m_ctrl[n] = '0; m_data[n] = '0;
    end
    e_mask = '0; e_arb = '0; e_ctrl = '0; e_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", 64'(busy), 64'd0);
    chk_ifr("R10 reset interface");
    run(ALL | 32'd17, "R10 reset object zero", 1'b0, 32'h0);

    // R1/R2: fill every object, then read all back.
    for (int n = 1; n <= N; n++) begin
      load(31'(pat(n, 1)), pat(n, 2), 16'(pat(n, 3)) & 16'h1FFF, pat(n, 4));
      run(WR | ALL | 32'hFF00_0000 | 32'(n), "R1 write keeps interface", 1'b0, 32'h0);
    end
    readback_all("R1 read all groups");

    // R2: every subset of groups on write, then on read.
    for (int g = 0; g < 16; g++) begin
      logic [31:0] f;
      f = (g[0] ? GM : 32'h0) | (g[1] ? GA : 32'h0) | (g[2] ? GC : 32'h0) | (g[3] ? GD : 32'h0);
      load(31'(pat(g, 7)), pat(g, 8), 16'(pat(g, 9)) & 16'h1FFF, pat(g, 10));
      run(WR | f | 32'd5, "R2 write subset", 1'b0, 32'h0);
      load(31'(pat(g, 11)), pat(g, 12), 16'(pat(g, 13)), pat(g, 14));
      run(f | 32'd7, "R2 read subset", 1'b0, 32'h0);
      run(ALL | 32'd5, "R2 write subset readback", 1'b0, 32'h0);
    end

    // R3/R4/R5: read with clears.
    load(31'h0, 32'h0, 16'hC0FF, 32'h0);
    run(WR | GC | 32'd9, "R3 setup", 1'b0, 32'h0);
    run(GC | CI | TX | 32'd9, "R5 pre-clear copy", 1'b0, 32'h0);
    chk(ifr_ctrl_q == 16'hC0FF, "R5 ctrl before clear", 64'(ifr_ctrl_q), 64'hC0FF);
    run(GC | 32'd9, "R3 R4 cleared", 1'b0, 32'h0);
    chk(ifr_ctrl_q == 16'h00FF, "R4 newdat and intpnd cleared", 64'(ifr_ctrl_q), 64'h00FF);
    load(31'h0, 32'h0, 16'hC001, 32'h0);
    run(WR | GC | 32'd11, "R3 setup 2", 1'b0, 32'h0);
    run(CI | 32'd11, "R3 clear only intpnd", 1'b0, 32'h0);
    run(GC | 32'd11, "R3 intpnd cleared", 1'b0, 32'h0);
    chk(ifr_ctrl_q == 16'h8001, "R3 only bit14 cleared", 64'(ifr_ctrl_q), 64'h8001);
    run(TX | 32'd11, "R4 clear only newdat", 1'b0, 32'h0);
    run(GC | 32'd11, "R4 newdat cleared", 1'b0, 32'h0);

    // R3: bit 19 ignored on write.
    load(31'h0, 32'h0, 16'h4000, 32'h0);
    run(WR | GC | CI | 32'd10, "R3 write ignores clear", 1'b0, 32'h0);
    run(WR | CI | 32'd12, "R3 write clear only", 1'b0, 32'h0);
    run(GC | 32'd10, "R3 intpnd kept", 1'b0, 32'h0);
    chk(ifr_ctrl_q == 16'h4000, "R3 bit14 from interface", 64'(ifr_ctrl_q), 64'h4000);

    // R6: transmit-request override.
    load(31'h0, 32'h0, 16'h0012, 32'h0);
    run(WR | GC | TX | 32'd13, "R6 override with ctrl", 1'b0, 32'h0);
    run(WR | TX | 32'd14, "R6 override without ctrl", 1'b0, 32'h0);
    run(GC | 32'd13, "R6 readback", 1'b0, 32'h0);
    chk(ifr_ctrl_q == 16'hA012, "R6 bits 15 and 13 set", 64'(ifr_ctrl_q), 64'hA012);
    run(GC | 32'd14, "R6 readback 2", 1'b0, 32'h0);
    load(31'h0, 32'h0, 16'h0000, 32'h0);
    run(WR | GC | 32'd14, "R6 no flag follows ctrl", 1'b0, 32'h0);
    run(GC | 32'd14, "R6 no flag readback", 1'b0, 32'h0);

    // R8/R11: strobes during busy ignored.
    load(31'h7, 32'h8, 16'h9, 32'hA);
    run(WR | ALL | 32'd15, "R11 load ignored while busy", 1'b1, WR | ALL | 32'd16);
    run(ALL | 32'd16, "R8 second command ignored", 1'b0, 32'h0);

    // R9: out-of-range numbers.
    bad(WR | ALL | 32'd0);
    bad(WR | ALL | 32'd33);
    bad(ALL | 32'd255);
    readback_all("R9 RAM unchanged");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule